// File: doc/BRIEF.md
# Subtractive GCD Processor

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. A controller and a datapath are kept as separate modules. The datapath holds two working registers, x and y. Each one has a two-way input selector that picks either the external operand or the output of a subtractor. The datapath also provides an equality test, a magnitude test and a result register. The controller is a thirteen-state machine. It drives the selectors and load enables and reacts to the datapath's status flags.

A client presents both operands and raises the start input. The machine checks the start input every other cycle while it idles. Once it sees start, it copies the first operand into x, then the second operand into y one state later. It then alternates between an inequality test and an ordering test, and subtracts the smaller register from the larger until the two are equal. At that point it writes the result register and gives a one-cycle completion pulse. If either operand is zero, it finishes at once with the other operand as the result.

Top module: `gcd_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the result output reads 0 and the completion pulse is low.
- R2: With the start input low, the machine never completes and the result output keeps its value.
- R3: For two nonzero operands, the result written after start is their greatest common divisor; for example, 42 and 8 give 2.
- R4: If one operand is zero, the result is the other operand; if both are zero, the result is 0.
- R5: The completion pulse is high for exactly one cycle, and it is high in the same cycle that the new result first appears.
- R6: The result output changes only in a cycle where the completion pulse is high, and it holds its value until the next completion.
- R7: The first operand is sampled in the state after start is seen and the second operand in the state after that. Operand changes after both captures do not affect the result.
- R8: Each subtraction takes the smaller working register from the larger one, so neither register ever wraps below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| d_o | output | WIDTH | Registered result |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that the operands stay steady from the rise of start until both have been captured. They also assume that start is dropped before the machine returns to idle, so that one request gives exactly one computation. The stimulus holds start for two cycles, which always covers one visit to the polling state. It keeps the operands steady for four cycles after start rises and only then scrambles them, so the result must come from the captured values alone. A narrow instance is swept over every operand pair, including the zero cases. A wider instance covers the 42/8 example and a few large pairs.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    // Controller state codes; the numeric order follows the algorithm steps.
    typedef enum logic [3:0] {
        ST_TOP    = 4'b0000,
        ST_POLL   = 4'b0001,
        ST_POLLJ  = 4'b0010,
        ST_LDX    = 4'b0011,
        ST_LDY    = 4'b0100,
        ST_NEQ    = 4'b0101,
        ST_LT     = 4'b0110,
        ST_SUBY   = 4'b0111,
        ST_SUBX   = 4'b1000,
        ST_LTJ    = 4'b1001,
        ST_NEQJ   = 4'b1010,
        ST_WRITE  = 4'b1011,
        ST_TOPJ   = 4'b1100
    } gcd_state_e;

    // Datapath steering produced by the controller.
    typedef struct packed {
        logic x_sel;   // 0: external operand, 1: subtractor
        logic y_sel;
        logic x_ld;
        logic y_ld;
        logic d_ld;
    } gcd_ctrl_t;

    // Flags returned by the datapath.
    typedef struct packed {
        logic neq;
        logic lt;
        logic zero;
    } gcd_stat_t;

    localparam gcd_ctrl_t CTRL_IDLE = '{default: 1'b0};

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go_i,
    input  gcd_stat_t stat_i,
    output gcd_ctrl_t ctrl_o
);

    gcd_state_e state_q;
    gcd_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_TOP;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = ST_TOP;
        ctrl_o  = CTRL_IDLE;
        case (state_q)
            ST_TOP:   state_d = ST_POLL;
            ST_POLL:  state_d = go_i ? ST_LDX : ST_POLLJ;
            ST_POLLJ: state_d = ST_POLL;
            ST_LDX: begin
                ctrl_o.x_sel = 1'b0;
                ctrl_o.x_ld  = 1'b1;
                state_d      = ST_LDY;
            end
            ST_LDY: begin
                ctrl_o.y_sel = 1'b0;
                ctrl_o.y_ld  = 1'b1;
                state_d      = ST_NEQ;
            end
            ST_NEQ:   state_d = (stat_i.neq && !stat_i.zero) ? ST_LT : ST_WRITE;
            ST_LT:    state_d = stat_i.lt ? ST_SUBY : ST_SUBX;
            ST_SUBY: begin
                ctrl_o.y_sel = 1'b1;
                ctrl_o.y_ld  = 1'b1;
                state_d      = ST_LTJ;
            end
            ST_SUBX: begin
                ctrl_o.x_sel = 1'b1;
                ctrl_o.x_ld  = 1'b1;
                state_d      = ST_LTJ;
            end
            ST_LTJ:   state_d = ST_NEQJ;
            ST_NEQJ:  state_d = ST_NEQ;
            ST_WRITE: begin
                ctrl_o.d_ld = 1'b1;
                state_d     = ST_TOPJ;
            end
            ST_TOPJ:  state_d = ST_POLL;
            default: begin
                state_d = ST_TOP;
                ctrl_o  = CTRL_IDLE;
            end
        endcase
    end

    // R2
    idle_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && !go_i) |=> (state_q == ST_POLLJ));

    // R7
    load_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && go_i) |=> (ctrl_o.x_ld && !ctrl_o.x_sel) ##1 (ctrl_o.y_ld && !ctrl_o.y_sel));

endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
    import gcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  gcd_ctrl_t        ctrl_i,
    output gcd_stat_t        stat_o,
    output logic [WIDTH-1:0] d_o,
    output logic             done_o
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] x_q, y_q, d_q;
    logic [WIDTH-1:0] x_diff, y_diff;
    logic [WIDTH-1:0] x_nx, y_nx, res;
    logic             done_q;

    assign x_diff = x_q - y_q;
    assign y_diff = y_q - x_q;
    assign x_nx   = ctrl_i.x_sel ? x_diff : x_i;
    assign y_nx   = ctrl_i.y_sel ? y_diff : y_i;

    // With x zero the answer is y; otherwise x (equal to y, or y is zero).
    assign res = (x_q == ZERO) ? y_q : x_q;

    assign stat_o.neq  = (x_q != y_q);
    assign stat_o.lt   = (x_q < y_q);
    assign stat_o.zero = (x_q == ZERO) || (y_q == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= ZERO;
            y_q    <= ZERO;
            d_q    <= ZERO;
            done_q <= 1'b0;
        end else begin
            if (ctrl_i.x_ld) x_q <= x_nx;
            if (ctrl_i.y_ld) y_q <= y_nx;
            if (ctrl_i.d_ld) d_q <= res;
            done_q <= ctrl_i.d_ld;
        end
    end

    assign d_o    = d_q;
    assign done_o = done_q;

    // R8
    no_underflow_y_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.y_ld && ctrl_i.y_sel) |-> (y_q > x_q));

    // R8
    no_underflow_x_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.x_ld && ctrl_i.x_sel) |-> (x_q > y_q));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(d_o));

endmodule

// File: rtl/gcd_core.sv
module gcd_core
    import gcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] d_o,
    output logic             done_o
);

    gcd_ctrl_t ctrl;
    gcd_stat_t stat;

    gcd_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go_i),
        .stat_i (stat),
        .ctrl_o (ctrl)
    );

    gcd_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk    (clk),
        .rst    (rst),
        .x_i    (x_i),
        .y_i    (y_i),
        .ctrl_i (ctrl),
        .stat_o (stat),
        .d_o    (d_o),
        .done_o (done_o)
    );

endmodule

// File: tb/gcd_core_tb.sv
`timescale 1ns/1ps
module gcd_core_tb_top;

    localparam int NW = 4;
    localparam int WW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          go_n = 1'b0;
    logic [NW-1:0] xn = '0, yn = '0;
    logic [NW-1:0] dn;
    logic          donen;

    logic          go_w = 1'b0;
    logic [WW-1:0] xw = '0, yw = '0;
    logic [WW-1:0] dw;
    logic          donew;

    gcd_core #(.WIDTH(NW)) dut_i (
        .clk(clk), .rst(rst), .go_i(go_n), .x_i(xn), .y_i(yn),
        .d_o(dn), .done_o(donen)
    );

    gcd_core #(.WIDTH(WW)) dut_w8_i (
        .clk(clk), .rst(rst), .go_i(go_w), .x_i(xw), .y_i(yw),
        .d_o(dw), .done_o(donew)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always @(posedge clk) cycles <= cycles + 1;

    function automatic int ref_gcd(input int a, input int b);
        int p = a;
        int q = b;
        while (q != 0) begin
            int t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_n(input int a, input int b);
        int exp = ref_gcd(a, b);
        int n = 0;
        int held;
        @(negedge clk);
        xn = NW'(a); yn = NW'(b); go_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        go_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R7: operands scrambled after capture
        xn = ~NW'(a); yn = NW'(b + 5);
        while (!donen && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (a == 0 || b == 0)
            check(donen && dn == NW'(exp), "R4", int'(dn), exp);
        else
            check(donen && dn == NW'(exp), "R3/R7", int'(dn), exp);
        held = int'(dn);
        @(negedge clk);
        // R5: pulse lasts one cycle
        check(!donen, "R5", int'(donen), 0);
        @(negedge clk);
        // R6: result held after completion
        check(int'(dn) == held, "R6", int'(dn), held);
    endtask

    task automatic run_w(input int a, input int b);
        int exp = ref_gcd(a, b);
        int n = 0;
        @(negedge clk);
        xw = WW'(a); yw = WW'(b); go_w = 1'b1;
        @(negedge clk);
        @(negedge clk);
        go_w = 1'b0;
        @(negedge clk);
        @(negedge clk);
        xw = WW'(a + 1); yw = WW'(b + 3);
        while (!donew && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(donew && dw == WW'(exp), (a == 0 || b == 0) ? "R4" : "R3", int'(dw), exp);
    endtask

    initial begin : watchdog
        wait (cycles > 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int last;
        @(negedge clk);
        // R1: outputs in reset
        check(dn == '0 && !donen, "R1", int'(dn), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dn == '0 && !donen && dw == '0 && !donew, "R1", int'(dn), 0);
        // R2: no start, nothing happens
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (donen || donew || dn != '0) seen = 1'b1;
            end
            check(!seen, "R2", int'(seen), 0);
        end
        for (int a = 0; a < (1 << NW); a++)
            for (int b = 0; b < (1 << NW); b++)
                run_n(a, b);
        // R2: idle after a result keeps the value
        last = int'(dn);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                if (donen || int'(dn) != last) seen = 1'b1;
            end
            check(!seen, "R2", int'(dn), last);
        end
        run_w(42, 8);
        run_w(255, 1);
        run_w(200, 75);
        run_w(0, 77);
        run_w(96, 96);
        run_w(128, 192);
        run_w(0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule